// File: doc/BRIEF.md
# Two-Wire Write-Only Register Slave

This block is a slave on a two-wire serial bus. The data line is open-drain, and the slave only writes registers. The block samples the bus clock and data line with a faster system clock. It finds start and stop conditions, shifts in an addressing byte and compares it against a fixed 7-bit device address. After the address byte it takes exactly two payload bytes, and it acknowledges the address byte and each payload byte by pulling the data line low.

The two payload bytes make up a 16-bit control word. The upper seven bits select a register and the lower nine bits are the value written to it. The ninth value bit travels as the last bit of the first payload byte. Once the second payload byte has been acknowledged, the block presents the register index and value on a one-cycle write strobe, which the register file reads.

A read request, an unknown address, an early stop or a start in the middle of a transfer all leave the slave silent until the next fresh start.

Top module: `twi_wr_slave`

## Requirements
- R1: A start is the synchronized data line going from 1 to 0 while the synchronized bus clock is 1 in two successive samples. A stop is the data line going from 0 to 1 under the same clock condition. Both inputs pass through two-flop synchronizers.
- R2: After a start from idle, the slave samples eight bits on the rising bus clock edges, MSB first. The first seven bits are the device address and the eighth is the direction bit, where 0 means write.
- R3: If the seven address bits equal 0011010 and the direction bit is 0, `sda_oe_o` (1 = pull the line low) rises after the falling bus clock edge that ends the eighth bit. It falls again after the falling edge that ends the ninth bit.
- R4: A different address, or a direction bit of 1, gets no acknowledge. All later bytes of that transfer are then ignored: no acknowledge and no write.
- R5: After an accepted address, the slave acknowledges each of the two payload bytes with the same timing as in R3.
- R6: Once the second payload byte's acknowledge has ended, `wr_valid_o` is high for exactly one system clock. At that point `wr_addr_o` equals bits 7..1 of payload byte 1, and `wr_data_o` equals bit 0 of payload byte 1 followed by the eight bits of payload byte 2.
- R7: A stop at any point returns the slave to idle and releases `sda_oe_o`. A stop that arrives before the second payload byte is complete produces no write.
- R8: A start that arrives while a transfer is in progress, or after a complete transfer but before its stop, returns the slave to idle without starting a new transfer. The bytes that follow get no acknowledge until a start is seen from idle.
- R9: During reset, `sda_oe_o` and `wr_valid_o` are 0 and `wr_addr_o` and `wr_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |
| wr_valid_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register index of the write |
| wr_data_o | output | 9 | Value of the write |

## Verification
The embedded properties check on every cycle that:
- the pull-down enable only rises and falls on a synchronized falling bus clock edge;
- a stop releases the line and never comes with a write;
- the write strobe is a single cycle that directly follows an acknowledge;
- a mid-transfer start forces idle.

Only the bench scenarios can show which addresses are accepted and how the payload bits are packed. The bench sweeps every 7-bit address and a range of register indices with computed values. It also covers recovery after read requests, early stops and restarts.

// File: rtl/twi_wr_pkg.sv
package twi_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_HOLD
  } twi_st_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/twi_wr_sync.sv
module twi_wr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_s, sda_s, scl_d, sda_d;

  // Reset to the idle bus level so no edge is seen at reset release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;

  p_start_clk_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(scl_s));
endmodule

// File: rtl/twi_wr_fsm.sv
module twi_wr_fsm
  import twi_wr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'b0011010,
  parameter int unsigned AW       = 7,
  parameter int unsigned DW       = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          sda_oe_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int unsigned FRAME_W = AW + DW;
  localparam int unsigned N_BYTES = FRAME_W / BYTE_W;
  localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);
  localparam int unsigned IDX_W   = $clog2(N_BYTES + 1);
  localparam int unsigned HI_DW   = BYTE_W - AW;

  twi_st_e            st_q;
  logic [BYTE_W-1:0]  shreg_q, hi_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [IDX_W-1:0]   byte_idx_q;
  logic               byte_done;

  assign byte_done = scl_fall_i && (bit_cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      shreg_q    <= '0;
      hi_q       <= '0;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        sda_oe_o   <= 1'b0;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        // Only a start from idle opens a transfer; any other start aborts.
        st_q       <= (st_q == ST_IDLE) ? ST_SHIFT : ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_SHIFT: begin
            if (scl_rise_i && bit_cnt_q < CNT_W'(BYTE_W)) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_done) begin
              if (byte_idx_q == '0) begin
                if (shreg_q == {DEV_ADDR, 1'b0}) begin
                  sda_oe_o <= 1'b1;
                  st_q     <= ST_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                if (byte_idx_q == IDX_W'(1)) hi_q <= shreg_q;
                sda_oe_o <= 1'b1;
                st_q     <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              if (byte_idx_q == IDX_W'(N_BYTES)) begin
                wr_valid_o <= 1'b1;
                wr_addr_o  <= hi_q[BYTE_W-1 -: AW];
                wr_data_o  <= {hi_q[HI_DW-1:0], shreg_q};
                st_q       <= ST_HOLD;
              end else begin
                byte_idx_q <= byte_idx_q + 1'b1;
                bit_cnt_q  <= '0;
                st_q       <= ST_SHIFT;
              end
            end
          end
          ST_HOLD: ;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_oe_rise_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));
  p_oe_drop_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && scl_fall_i) |=> !sda_oe_o);
  p_strobe_after_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_valid_o) |-> $past(sda_oe_o));
  p_strobe_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  p_stop_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sda_oe_o && !wr_valid_o && st_q == ST_IDLE));
  p_start_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q != ST_IDLE) |=> st_q == ST_IDLE);
endmodule

// File: rtl/twi_wr_slave.sv
module twi_wr_slave #(
  parameter logic [6:0]  DEV_ADDR    = 7'b0011010,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AW          = 7,
  parameter int unsigned DW          = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  twi_wr_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );
endmodule

// File: tb/twi_wr_slave_tb.sv
module twi_wr_slave_tb_top;
  localparam int Q         = 6;       // system clocks per bus quarter phase
  localparam int WD_LIMIT  = 150000;
  localparam logic [6:0] DEV = 7'b0011010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe, wr_valid;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;
  int checks = 0, errors = 0, cycles = 0;
  int n_strobe = 0;
  logic [6:0] cap_addr = '0;
  logic [8:0] cap_data = '0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  twi_wr_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(posedge clk) if (rst_n && wr_valid) begin
    n_strobe <= n_strobe + 1;
    cap_addr <= wr_addr;
    cap_data <= wr_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  // Sends a byte plus the ninth clock; reports acknowledge and release.
  task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = !sda_line;
    scl_m = 1'b0; wq(Q);
    rel = !sda_oe;
  endtask

  task automatic full_write(input logic [6:0] ra, input logic [8:0] d);
    bit a0, a1, a2, r0, r1, r2;
    int base;
    base = n_strobe;
    bus_start();
    send_byte({DEV, 1'b0}, a0, r0);
    send_byte({ra, d[8]}, a1, r1);
    send_byte(d[7:0], a2, r2);
    wq(2);
    check(a0, "R3 address ack", a0, 1);
    check(a1 && a2, "R5 payload acks", {a1, a2}, 3);
    check(r0 && r1 && r2, "R5 ack release", {r0, r1, r2}, 7);
    check(n_strobe == base + 1, "R6 one strobe", n_strobe - base, 1);
    check(cap_addr == ra, "R6 register index", cap_addr, ra);
    check(cap_data == d, "R6 value", cap_data, d);
    bus_stop();
    check(n_strobe == base + 1, "R7 no extra strobe at stop", n_strobe - base, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        errors++;
        $display("FAIL watchdog cycles=%0d expected<=%0d", cycles, WD_LIMIT);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bit ack, rel;
    int base;
    wq(4);
    check(sda_oe == 1'b0, "R9 reset oe", sda_oe, 0);
    check(wr_valid == 1'b0, "R9 reset strobe", wr_valid, 0);
    check(wr_addr == '0, "R9 reset index", wr_addr, 0);
    check(wr_data == '0, "R9 reset value", wr_data, 0);
    rst_n = 1'b1;
    wq(4);

    // R2/R3/R4: every address with write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, ack, rel);
      check(ack == (a == int'(DEV)), "R2 R3 R4 address sweep", ack, a == int'(DEV));
      check(rel, "R3 release after ack bit", rel, 1);
      bus_stop();
    end

    // R4: read request ignored, later bytes ignored
    base = n_strobe;
    bus_start();
    send_byte({DEV, 1'b1}, ack, rel);
    check(!ack, "R4 read rejected", ack, 0);
    send_byte(8'h55, ack, rel);
    check(!ack, "R4 later byte ignored", ack, 0);
    send_byte(8'hAA, ack, rel);
    check(!ack && n_strobe == base, "R4 no write", n_strobe - base, 0);
    bus_stop();

    // R6: register index sweep with computed values
    for (int r = 0; r < 128; r += 3)
      full_write(r[6:0], 9'((r * 37 + 11) % 512));
    full_write(7'h7F, 9'h1FF);
    full_write(7'h00, 9'h100);

    // R7: stop after first payload byte
    base = n_strobe;
    bus_start();
    send_byte({DEV, 1'b0}, ack, rel);
    send_byte(8'h13, ack, rel);
    check(ack, "R7 first payload acked", ack, 1);
    bus_stop();
    check(n_strobe == base && !sda_oe, "R7 early stop no write", n_strobe - base, 0);

    // R7: stop mid second byte
    bus_start();
    send_byte({DEV, 1'b0}, ack, rel);
    send_byte(8'h21, ack, rel);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check(n_strobe == base, "R7 partial byte no write", n_strobe - base, 0);

    // R8: start inside payload byte aborts, next bytes ignored
    bus_start();
    send_byte({DEV, 1'b0}, ack, rel);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    send_byte({DEV, 1'b0}, ack, rel);
    check(!ack, "R8 restart not served", ack, 0);
    send_byte(8'h44, ack, rel);
    send_byte(8'h44, ack, rel);
    check(!ack && n_strobe == base, "R8 no write after abort", n_strobe - base, 0);
    bus_stop();

    // R8: start after complete transfer but before stop
    full_write(7'h2A, 9'h0C3);
    base = n_strobe;
    bus_start();
    send_byte({DEV, 1'b0}, ack, rel);
    send_byte(8'h02, ack, rel);
    send_byte(8'h03, ack, rel);
    wq(2);
    bus_start();
    send_byte({DEV, 1'b0}, ack, rel);
    check(!ack, "R8 start before stop aborts", ack, 0);
    check(n_strobe == base + 1, "R8 first transfer kept", n_strobe - base, 1);
    bus_stop();

    // R1: recovery after stop, a fresh start is seen
    full_write(7'h15, 9'h0A5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule